// File: doc/BRIEF.md
# Dual-Slot Instruction Packet Dispatcher

The dispatcher takes one 32-bit fetched instruction word at a time and turns it into a sequence of operations for an execute stage. The two top bits classify the word. It is either a single long operation filling the low 30 bits, or a pair of 15-bit short operations. A pair issues in one of three ways: one slot after the other in a fixed order (right slot first or left slot first), or as a parallel pair. In a parallel pair, an operation that only tests a condition goes first, and its result decides whether its partner runs.

For every operation it issues, the block presents the operation bits, the slot it came from and a 6-bit opcode-table index. Execute answers a lookup on the held word. For each slot it says whether the index matches a table entry of the right size and whether that entry is a test-only operation. A word whose opcode matches nothing raises a trap and issues nothing. Single-cycle event pulses report accepted words, the extra cycle taken by a second sequential issue, sequential pairs cut short by a branch, and predicated operations that were dropped.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset the block is idle: `word_ready_o`=1, `iss_valid_o`=0, and `trap_o`, `ev_cycle_o`, `ev_skip_o`, `ev_cfalse_o` are all 0.
- R2: Format code 2'b11 in bits 31:30 is a long word. Exactly one operation issues, with `iss_long_o`=1, `iss_slot_o`=0, `iss_op_o`=word[29:0] and `iss_idx_o`=word[29:24].
- R3: In every short format, the left slot is word[29:15] and the right slot is word[14:0]. A short operation issues zero-extended on `iss_op_o` with `iss_long_o`=0 and `iss_slot_o` 0 for left, 1 for right. Its index is bits 14:9 of the 15-bit slot.
- R4: Code 2'b01 issues left then right. Code 2'b10 issues right then left.
- R5: In a sequential pair (code 01 or 10), if `pc_changed_i` is 1 at the handshake of the first operation, the second never issues and `ev_skip_o` pulses once.
- R6: In a parallel pair (code 2'b00), a slot flagged test-only issues first, and the left flag is checked before the right. The partner issues only if `cond_i` is 1 at the test operation's handshake. Otherwise it is dropped and `ev_cfalse_o` pulses once.
- R7: In a parallel pair with neither slot flagged test-only, left issues and then right, whatever `cond_i` is.
- R8: If the lookup reports no match (left hit for a long word, either hit for a short pair), `trap_o` pulses once and no operation issues for that word.
- R9: `ev_cycle_o` pulses once for each accepted word. It pulses once more when the second operation of a sequential pair issues.
- R10: A word is accepted only while `word_ready_o`=1 (idle). A `word_valid_i` seen while busy is ignored. While `iss_valid_o`=1 and `iss_ready_i`=0, the issued operation, slot and index hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 32 | Fetched instruction word |
| word_valid_i | input | 1 | Fetched word present |
| word_ready_o | output | 1 | Block idle, word taken on this cycle if valid |
| lk_long_o | output | 1 | Lookup: held word is a long operation |
| lk_idx_l_o | output | 6 | Lookup index: long index or left slot index |
| lk_idx_r_o | output | 6 | Lookup index: right slot index |
| lk_hit_l_i | input | 1 | Left or long index matches a table entry of right size |
| lk_hit_r_i | input | 1 | Right index matches a short table entry |
| lk_tonly_l_i | input | 1 | Left entry is a condition-test-only operation |
| lk_tonly_r_i | input | 1 | Right entry is a condition-test-only operation |
| iss_valid_o | output | 1 | Operation offered to execute |
| iss_ready_i | input | 1 | Execute accepts the offered operation |
| iss_long_o | output | 1 | Offered operation is long |
| iss_slot_o | output | 1 | Slot of offered operation (0 left, 1 right) |
| iss_op_o | output | 30 | Offered operation bits |
| iss_idx_o | output | 6 | Opcode-table index of offered operation |
| pc_changed_i | input | 1 | First operation changed the PC (valid at its handshake) |
| cond_i | input | 1 | Test result (valid at the test operation's handshake) |
| trap_o | output | 1 | Illegal-instruction trap pulse |
| ev_cycle_o | output | 1 | Cycle event pulse |
| ev_skip_o | output | 1 | Sequential second operation skipped by branch |
| ev_cfalse_o | output | 1 | Predicated operation dropped on false condition |

## Verification
`ev_cycle_o` for an accepted word rises one cycle after the accepting edge. The lookup is sampled on the next edge, so the first operation is offered two cycles after acceptance, or `trap_o` pulses then instead. The skip, condition-false and second-issue cycle pulses appear one cycle after the handshake that decides them. The bench keeps a scoreboard of expected operations built from the format and flags. The monitor samples handshakes and event pulses on falling edges, where every registered result is stable. Event totals are compared only after the block is back in idle, so each pulse's exact cycle does not matter to the count, and a toggling ready tests the hold-while-stalled rule.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    PM_SOLO,
    PM_SEQ,
    PM_COND,
    PM_PAR
  } pair_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FIRST,
    ST_SECOND,
    ST_DONE
  } st_e;

  localparam logic SLOT_L = 1'b0;
  localparam logic SLOT_R = 1'b1;
endpackage

// File: rtl/pd_fields.sv
module pd_fields #(
  parameter int SLOT_W = 15,
  parameter int IDX_W  = 6,
  localparam int OP_W   = 2 * SLOT_W,
  localparam int WORD_W = OP_W + 2
) (
  input  logic [WORD_W-1:0]          word_i,
  output pd_pkg::fmt_e               fmt_o,
  output logic [OP_W-1:0]            long_op_o,
  output logic [IDX_W-1:0]           long_idx_o,
  output logic [1:0][SLOT_W-1:0]     slot_o,
  output logic [1:0][IDX_W-1:0]      slot_idx_o
);
  assign fmt_o      = pd_pkg::fmt_e'(word_i[WORD_W-1 -: 2]);
  assign long_op_o  = word_i[OP_W-1:0];
  assign long_idx_o = word_i[OP_W-1 -: IDX_W];

  // index 0 = right slot (low bits), index 1 = left slot
  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign slot_o[s]     = word_i[s*SLOT_W +: SLOT_W];
    assign slot_idx_o[s] = word_i[s*SLOT_W + SLOT_W - 1 -: IDX_W];
  end
endmodule

// File: rtl/pd_order.sv
module pd_order (
  input  pd_pkg::fmt_e  fmt_i,
  input  logic          tonly_l_i,
  input  logic          tonly_r_i,
  output pd_pkg::pair_e mode_o,
  output logic          first_o
);
  import pd_pkg::*;
  always_comb begin
    mode_o  = PM_SOLO;
    first_o = SLOT_L;
    case (fmt_i)
      FMT_LONG: begin mode_o = PM_SOLO; first_o = SLOT_L; end
      FMT_LR:   begin mode_o = PM_SEQ;  first_o = SLOT_L; end
      FMT_RL:   begin mode_o = PM_SEQ;  first_o = SLOT_R; end
      default: begin
        if (tonly_l_i) begin
          mode_o = PM_COND; first_o = SLOT_L;
        end else if (tonly_r_i) begin
          mode_o = PM_COND; first_o = SLOT_R;
        end else begin
          mode_o = PM_PAR;  first_o = SLOT_L;
        end
      end
    endcase
  end
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch #(
  parameter int SLOT_W = 15,
  parameter int IDX_W  = 6,
  localparam int OP_W   = 2 * SLOT_W,
  localparam int WORD_W = OP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              lk_long_o,
  output logic [IDX_W-1:0]  lk_idx_l_o,
  output logic [IDX_W-1:0]  lk_idx_r_o,
  input  logic              lk_hit_l_i,
  input  logic              lk_hit_r_i,
  input  logic              lk_tonly_l_i,
  input  logic              lk_tonly_r_i,
  output logic              iss_valid_o,
  input  logic              iss_ready_i,
  output logic              iss_long_o,
  output logic              iss_slot_o,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [IDX_W-1:0]  iss_idx_o,
  input  logic              pc_changed_i,
  input  logic              cond_i,
  output logic              trap_o,
  output logic              ev_cycle_o,
  output logic              ev_skip_o,
  output logic              ev_cfalse_o
);
  import pd_pkg::*;

  st_e                   st;
  logic [WORD_W-1:0]     word_q;
  pair_e                 mode_q;
  logic                  first_q;

  fmt_e                  fmt;
  logic [OP_W-1:0]       long_op;
  logic [IDX_W-1:0]      long_idx;
  logic [1:0][SLOT_W-1:0] slot;
  logic [1:0][IDX_W-1:0] slot_idx;
  pair_e                 ord_mode;
  logic                  ord_first;
  logic                  legal;
  logic                  cur_slot;
  logic                  hs;

  pd_fields #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_fields (
    .word_i     (word_q),
    .fmt_o      (fmt),
    .long_op_o  (long_op),
    .long_idx_o (long_idx),
    .slot_o     (slot),
    .slot_idx_o (slot_idx)
  );

  pd_order u_order (
    .fmt_i     (fmt),
    .tonly_l_i (lk_tonly_l_i),
    .tonly_r_i (lk_tonly_r_i),
    .mode_o    (ord_mode),
    .first_o   (ord_first)
  );

  assign lk_long_o   = (fmt == FMT_LONG);
  assign lk_idx_l_o  = lk_long_o ? long_idx : slot_idx[1];
  assign lk_idx_r_o  = slot_idx[0];
  assign legal       = lk_long_o ? lk_hit_l_i : (lk_hit_l_i & lk_hit_r_i);

  assign word_ready_o = (st == ST_IDLE);
  assign iss_valid_o  = (st == ST_FIRST) || (st == ST_SECOND);
  assign iss_long_o   = lk_long_o;
  assign cur_slot     = (st == ST_SECOND) ? ~first_q : first_q;
  assign hs           = iss_valid_o & iss_ready_i;

  always_comb begin
    if (lk_long_o) begin
      iss_op_o   = long_op;
      iss_idx_o  = long_idx;
      iss_slot_o = SLOT_L;
    end else if (cur_slot == SLOT_R) begin
      iss_op_o   = {{(OP_W-SLOT_W){1'b0}}, slot[0]};
      iss_idx_o  = slot_idx[0];
      iss_slot_o = SLOT_R;
    end else begin
      iss_op_o   = {{(OP_W-SLOT_W){1'b0}}, slot[1]};
      iss_idx_o  = slot_idx[1];
      iss_slot_o = SLOT_L;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      word_q      <= '0;
      mode_q      <= PM_SOLO;
      first_q     <= SLOT_L;
      trap_o      <= 1'b0;
      ev_cycle_o  <= 1'b0;
      ev_skip_o   <= 1'b0;
      ev_cfalse_o <= 1'b0;
    end else begin
      trap_o      <= 1'b0;
      ev_cycle_o  <= 1'b0;
      ev_skip_o   <= 1'b0;
      ev_cfalse_o <= 1'b0;
      case (st)
        ST_IDLE: if (word_valid_i) begin
          word_q     <= word_i;
          ev_cycle_o <= 1'b1;
          st         <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!legal) begin
            trap_o <= 1'b1;
            st     <= ST_DONE;
          end else begin
            mode_q  <= ord_mode;
            first_q <= ord_first;
            st      <= ST_FIRST;
          end
        end
        ST_FIRST: if (hs) begin
          case (mode_q)
            PM_SEQ: begin
              if (pc_changed_i) begin
                ev_skip_o <= 1'b1;
                st        <= ST_DONE;
              end else begin
                st <= ST_SECOND;
              end
            end
            PM_COND: begin
              if (cond_i) begin
                st <= ST_SECOND;
              end else begin
                ev_cfalse_o <= 1'b1;
                st          <= ST_DONE;
              end
            end
            PM_PAR:  st <= ST_SECOND;
            default: st <= ST_DONE;
          endcase
        end
        ST_SECOND: if (hs) begin
          if (mode_q == PM_SEQ) ev_cycle_o <= 1'b1;
          st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_dispatch_chk.sv
module pkt_dispatch_chk #(
  parameter int SLOT_W = 15,
  parameter int IDX_W  = 6,
  localparam int OP_W  = 2 * SLOT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid_i,
  input logic             word_ready_o,
  input logic             iss_valid_o,
  input logic             iss_ready_i,
  input logic             iss_long_o,
  input logic             iss_slot_o,
  input logic [OP_W-1:0]  iss_op_o,
  input logic [IDX_W-1:0] iss_idx_o,
  input logic             trap_o,
  input logic             ev_cycle_o,
  input logic             ev_skip_o,
  input logic             ev_cfalse_o
);
  // R10: an offered operation holds while execute stalls
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    iss_valid_o && !iss_ready_i |=> iss_valid_o && $stable(iss_op_o)
      && $stable(iss_slot_o) && $stable(iss_idx_o) && $stable(iss_long_o));

  // R10: never idle while offering an operation; an accepted word makes the block busy
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    iss_valid_o |-> !word_ready_o);
  p_take_r10: assert property (@(posedge clk) disable iff (rst)
    word_valid_i && word_ready_o |=> !word_ready_o);

  // R8: a trap comes with no issue, now or next cycle
  p_trap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !iss_valid_o ##1 !iss_valid_o);

  // R5 and R6: drop events never coincide with an offered operation
  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ev_skip_o |-> !iss_valid_o);
  p_cfalse_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ev_cfalse_o |-> !iss_valid_o);
  p_ev_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_o, ev_skip_o, ev_cfalse_o}));

  // R9: cycle pulses are single-cycle
  p_cycle_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ev_cycle_o |=> !ev_cycle_o);

  // R3: short operations are zero-extended and indexed by their top bits
  p_short_ext_r3: assert property (@(posedge clk) disable iff (rst)
    iss_valid_o && !iss_long_o |->
      iss_op_o[OP_W-1:SLOT_W] == '0 && iss_idx_o == iss_op_o[SLOT_W-1 -: IDX_W]);

  // R2: a long operation comes from the left-slot position
  p_long_slot_r2: assert property (@(posedge clk) disable iff (rst)
    iss_valid_o && iss_long_o |-> iss_slot_o == 1'b0);
endmodule

bind pkt_dispatch pkt_dispatch_chk #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .word_valid_i(word_valid_i), .word_ready_o(word_ready_o),
  .iss_valid_o(iss_valid_o), .iss_ready_i(iss_ready_i), .iss_long_o(iss_long_o),
  .iss_slot_o(iss_slot_o), .iss_op_o(iss_op_o), .iss_idx_o(iss_idx_o),
  .trap_o(trap_o), .ev_cycle_o(ev_cycle_o), .ev_skip_o(ev_skip_o),
  .ev_cfalse_o(ev_cfalse_o));

// File: tb/pkt_dispatch_test.sv
module pkt_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 15;
  localparam int IW = 6;
  localparam int OW = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] word_i = '0;
  logic word_valid_i = 1'b0;
  logic word_ready_o, lk_long_o;
  logic [IW-1:0] lk_idx_l_o, lk_idx_r_o;
  logic lk_hit_l_i = 1'b1, lk_hit_r_i = 1'b1, lk_tonly_l_i = 1'b0, lk_tonly_r_i = 1'b0;
  logic iss_valid_o, iss_ready_i = 1'b1, iss_long_o, iss_slot_o;
  logic [OW-1:0] iss_op_o;
  logic [IW-1:0] iss_idx_o;
  logic pc_changed_i = 1'b0, cond_i = 1'b0;
  logic trap_o, ev_cycle_o, ev_skip_o, ev_cfalse_o;

  pkt_dispatch #(.SLOT_W(SW), .IDX_W(IW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [OW-1:0] op;
    logic          slot;
    logic          lng;
    logic [IW-1:0] idx;
  } item_t;

  item_t expq[$];
  int checks = 0, fails = 0;
  string tag = "R1";
  int n_cyc = 0, n_skip = 0, n_cf = 0, n_trap = 0;
  logic stall = 1'b0;
  bit finished = 0;

  always @(posedge clk) begin
    #1;
    iss_ready_i = stall ? ~iss_ready_i : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    item_t got, e;
    if (!rst) begin
      if (ev_cycle_o)  n_cyc++;
      if (ev_skip_o)   n_skip++;
      if (ev_cfalse_o) n_cf++;
      if (trap_o)      n_trap++;
      if (iss_valid_o && iss_ready_i) begin
        got = {iss_op_o, iss_slot_o, iss_long_o, iss_idx_o};
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected issue actual op=%h slot=%0d expected none", tag, iss_op_o, iss_slot_o);
        end else begin
          e = expq.pop_front();
          if (got !== e) begin
            fails++;
            $display("FAIL %s issue actual op=%h slot=%0d long=%0d idx=%h expected op=%h slot=%0d long=%0d idx=%h",
                     tag, got.op, got.slot, got.lng, got.idx, e.op, e.slot, e.lng, e.idx);
          end
        end
      end
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic item_t mk(logic [31:0] w, logic sl, logic lg);
    item_t t;
    t.lng = lg;
    if (lg) begin
      t.op = w[29:0]; t.idx = w[29:24]; t.slot = 1'b0;
    end else if (!sl) begin
      t.op = {15'b0, w[29:15]}; t.idx = w[29:24]; t.slot = 1'b0;
    end else begin
      t.op = {15'b0, w[14:0]}; t.idx = w[14:9]; t.slot = 1'b1;
    end
    return t;
  endfunction

  task automatic run_word(string t, logic [31:0] w, logic hl, logic hr, logic tl, logic tr,
                          logic pcc, logic cnd, logic inject);
    int e_cyc = 1, e_skip = 0, e_cf = 0, e_trap = 0;
    int c0, s0, f0, t0;
    logic lg = (w[31:30] == 2'b11);
    logic legal = lg ? hl : (hl & hr);
    tag = t;
    if (!legal) e_trap = 1;
    else case (w[31:30])
      2'b11: expq.push_back(mk(w, 0, 1));
      2'b01: begin
        expq.push_back(mk(w, 0, 0));
        if (!pcc) begin expq.push_back(mk(w, 1, 0)); e_cyc++; end else e_skip = 1;
      end
      2'b10: begin
        expq.push_back(mk(w, 1, 0));
        if (!pcc) begin expq.push_back(mk(w, 0, 0)); e_cyc++; end else e_skip = 1;
      end
      default: begin
        if (tl) begin
          expq.push_back(mk(w, 0, 0));
          if (cnd) expq.push_back(mk(w, 1, 0)); else e_cf = 1;
        end else if (tr) begin
          expq.push_back(mk(w, 1, 0));
          if (cnd) expq.push_back(mk(w, 0, 0)); else e_cf = 1;
        end else begin
          expq.push_back(mk(w, 0, 0));
          expq.push_back(mk(w, 1, 0));
        end
      end
    endcase
    c0 = n_cyc; s0 = n_skip; f0 = n_cf; t0 = n_trap;
    @(negedge clk);
    lk_hit_l_i = hl; lk_hit_r_i = hr; lk_tonly_l_i = tl; lk_tonly_r_i = tr;
    pc_changed_i = pcc; cond_i = cnd;
    word_i = w; word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0;
    if (inject) begin
      word_i = ~w; word_valid_i = 1'b1;
      repeat (2) @(negedge clk);
      word_valid_i = 1'b0;
    end
    while (!word_ready_o) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(t, "pending expected issues", expq.size(), 0);
    expq.delete();
    chk("R9", "cycle events", n_cyc - c0, e_cyc);
    chk("R5", "skip events", n_skip - s0, e_skip);
    chk("R6", "cond-false events", n_cf - f0, e_cf);
    chk("R8", "trap events", n_trap - t0, e_trap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "word_ready", word_ready_o, 1);
    chk("R1", "iss_valid", iss_valid_o, 0);
    chk("R1", "events", {trap_o, ev_cycle_o, ev_skip_o, ev_cfalse_o}, 0);

    run_word("R2 long",                 32'hC7A5_1234, 1, 0, 0, 0, 0, 0, 0);
    run_word("R3 R4 left-first",        32'h5A5A_1234, 1, 1, 0, 0, 0, 0, 0);
    run_word("R4 right-first",          32'h8123_4567, 1, 1, 0, 0, 0, 0, 0);
    run_word("R5 left-first branch",    32'h5A5A_1234, 1, 1, 0, 0, 1, 0, 0);
    run_word("R5 right-first branch",   32'hB0F0_7E01, 1, 1, 0, 0, 1, 1, 0);
    run_word("R7 parallel plain",       32'h1357_9BDF, 1, 1, 0, 0, 1, 0, 0);
    run_word("R6 left test true",       32'h2468_ACE0, 1, 1, 1, 0, 0, 1, 0);
    run_word("R6 left test false",      32'h2468_ACE0, 1, 1, 1, 0, 0, 0, 0);
    run_word("R6 right test false",     32'h0F1E_2D3C, 1, 1, 0, 1, 0, 0, 0);
    run_word("R6 right test true",      32'h0F1E_2D3C, 1, 1, 0, 1, 0, 1, 0);
    run_word("R6 both test left first", 32'h3FFF_0001, 1, 1, 1, 1, 0, 0, 0);
    run_word("R8 short right miss",     32'h5A5A_1234, 1, 0, 0, 0, 0, 0, 0);
    run_word("R8 long miss",            32'hC7A5_1234, 0, 1, 0, 0, 0, 0, 0);
    stall = 1'b1;
    run_word("R10 stalled seq busy",    32'h6BCD_EF01, 1, 1, 0, 0, 0, 0, 1);
    run_word("R10 stalled parallel",    32'h1357_9BDF, 1, 1, 0, 0, 0, 0, 1);
    stall = 1'b0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=busy expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule